// File: doc/BRIEF.md
# Context Validation Tag Unit

This unit makes and checks the one-byte validity tag kept next to each connection context. From a 24-bit connection ID, a 4-bit region number and a 4-bit type, it builds a 32-bit word and runs an 8-bit CRC over the whole word in one step. It then forms a tag from the result: the top bit marks the context as valid and the low seven bits hold the CRC.

A 2-bit operation code picks one of three actions. Generate returns a fresh tag. Check recomputes the tag and compares it with a stored tag that the caller supplies. Invalidate clears the validity bit of a supplied tag and keeps its other bits. Each operation is accepted with an input strobe, and its results appear one clock later with an output strobe. The unit also flags when the region is one of the two aggregation regions, 2 and 4. The contexts themselves are stored outside this unit.

Top module: `ctx_tag_unit`

## Requirements
- R1: The CRC word is {cid_i, region_i, type_i}: the ID in bits [31:8], the region in bits [7:4] and the type in bits [3:0].
- R2: The CRC uses the polynomial x^8+x^2+x+1 (0x07) with a seed of 0xFF. It equals a bit-serial CRC that takes the word MSB first. CRC bit 0 is the XOR of word bits 31,30,28,23,21,19,18,16,14,12,8,7,6,0 and seed bits 4,6,7.
- R3: With mode_i = 2'b00 (generate), tag_o is {1'b1, crc[6:0]} and match_o is 0.
- R4: With mode_i = 2'b01 (check), tag_o is {1'b1, crc[6:0]}. match_o is 1 only when tag_i[7] is 1 and tag_i[6:0] equals crc[6:0].
- R5: With mode_i[1] = 1 (invalidate, codes 2'b10 and 2'b11), tag_o is tag_i with bit 7 cleared and bits [6:0] unchanged, and match_o is 0.
- R6: out_valid_o is 1 in exactly the cycle after a cycle in which in_valid_i was 1. tag_o, match_o and agg_o change in that same cycle.
- R7: While rst_ni is low, out_valid_o, tag_o, match_o and agg_o are all 0.
- R8: agg_o is 1 when the accepted region is 2 or 4, and 0 for any other region.
- R9: When in_valid_i is low, tag_o, match_o and agg_o keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Accept an operation this cycle |
| mode_i | input | 2 | 00 generate, 01 check, 1x invalidate |
| cid_i | input | 24 | Connection ID |
| region_i | input | 4 | Region number |
| type_i | input | 4 | Context type |
| tag_i | input | 8 | Stored tag for check or invalidate |
| out_valid_o | output | 1 | Results valid |
| tag_o | output | 8 | Fresh or invalidated tag |
| match_o | output | 1 | Stored tag matches the recomputed tag |
| agg_o | output | 1 | Region is an aggregation region |

## Verification
Every result is due exactly one clock edge after the cycle in which its operation was presented with in_valid_i high. While in_valid_i is low, the previous results must stay unchanged. The bench drives each operation on a falling edge. At the next falling edge it compares all four outputs with the values that its bit-serial model predicted from the inputs one cycle earlier, so each comparison lands half a period after the register updates. Idle cycles with random values on the other inputs check that the held values do not move.

// File: rtl/ctx_tag_pkg.sv
package ctx_tag_pkg;
  typedef enum logic [1:0] {
    OP_GEN      = 2'b00,
    OP_CHECK    = 2'b01,
    OP_INVAL    = 2'b10,
    OP_INVAL_X  = 2'b11
  } tag_op_e;

  localparam int unsigned AGG_REGION_A = 2;
  localparam int unsigned AGG_REGION_B = 4;
endpackage

// File: rtl/ctx_crc8_par.sv
module ctx_crc8_par #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CRC_W  = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h07,
  parameter logic [CRC_W-1:0] SEED = 8'hFF
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  // serial LFSR, used only at elaboration to derive XOR masks
  function automatic logic [CRC_W-1:0] lfsr_run(input logic [DATA_W-1:0] w,
                                                input logic [CRC_W-1:0] s);
    logic [CRC_W-1:0] c;
    logic fb;
    c = s;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ w[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] col_mask(input int k);
    logic [DATA_W-1:0] m;
    logic [CRC_W-1:0] r;
    for (int j = 0; j < DATA_W; j++) begin
      r    = lfsr_run(DATA_W'(1) << j, '0);
      m[j] = r[k];
    end
    return m;
  endfunction

  localparam logic [CRC_W-1:0] SEED_TERM = lfsr_run('0, SEED);

  for (genvar k = 0; k < CRC_W; k++) begin : g_bit
    localparam logic [DATA_W-1:0] MASK = col_mask(k);
    assign crc_o[k] = (^(data_i & MASK)) ^ SEED_TERM[k];
  end

  // R2: bit 0 against the fixed equation for the default configuration
  if (DATA_W == 32 && CRC_W == 8 && POLY == 8'h07 && SEED == 8'hFF) begin : g_chk
    always_comb begin
      a_r2_bit0_eqn: assert (crc_o[0] == ((^(data_i & 32'hD0AD_51C1)) ^ 1'b1));
    end
  end
endmodule

// File: rtl/ctx_tag_fmt.sv
module ctx_tag_fmt
  import ctx_tag_pkg::*;
#(
  parameter int unsigned TAG_W = 8
) (
  input  tag_op_e          op_i,
  input  logic [TAG_W-1:0] crc_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             match_o
);
  localparam int unsigned VB = TAG_W - 1;

  logic [TAG_W-1:0] fresh;
  assign fresh = {1'b1, crc_i[VB-1:0]};

  always_comb begin
    tag_o   = fresh;
    match_o = 1'b0;
    unique case (op_i)
      OP_GEN:   ;
      OP_CHECK: match_o = tag_i[VB] && (tag_i[VB-1:0] == crc_i[VB-1:0]);
      default:  tag_o = {1'b0, tag_i[VB-1:0]};
    endcase
  end
endmodule

// File: rtl/ctx_tag_unit.sv
module ctx_tag_unit
  import ctx_tag_pkg::*;
#(
  parameter int unsigned CID_W = 24,
  parameter int unsigned REG_W = 4,
  parameter int unsigned TYP_W = 4,
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [1:0]       mode_i,
  input  logic [CID_W-1:0] cid_i,
  input  logic [REG_W-1:0] region_i,
  input  logic [TYP_W-1:0] type_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             out_valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             match_o,
  output logic             agg_o
);
  localparam int unsigned WORD_W = CID_W + REG_W + TYP_W;

  logic [WORD_W-1:0] word;
  logic [TAG_W-1:0]  crc;
  logic [TAG_W-1:0]  tag_d;
  logic              match_d;
  logic              agg_d;

  assign word  = {cid_i, region_i, type_i};
  assign agg_d = (region_i == REG_W'(AGG_REGION_A)) || (region_i == REG_W'(AGG_REGION_B));

  ctx_crc8_par #(
    .DATA_W(WORD_W),
    .CRC_W (TAG_W),
    .POLY  (TAG_W'(8'h07)),
    .SEED  ({TAG_W{1'b1}})
  ) u_crc (
    .data_i(word),
    .crc_o (crc)
  );

  ctx_tag_fmt #(.TAG_W(TAG_W)) u_fmt (
    .op_i   (tag_op_e'(mode_i)),
    .crc_i  (crc),
    .tag_i  (tag_i),
    .tag_o  (tag_d),
    .match_o(match_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      tag_o       <= '0;
      match_o     <= 1'b0;
      agg_o       <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        tag_o   <= tag_d;
        match_o <= match_d;
        agg_o   <= agg_d;
      end
    end
  end

  a_r6_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r6_idle_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  a_r3_gen_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 2'b00) |=> (tag_o[TAG_W-1] && !match_o));
  a_r4_no_match_on_stale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 2'b01 && !tag_i[TAG_W-1]) |=> !match_o);
  a_r5_inval_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i[1]) |=>
      (tag_o == {1'b0, $past(tag_i[TAG_W-2:0])}) && !match_o);
  a_r8_agg_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (agg_o == ($past(region_i) == REG_W'(2) || $past(region_i) == REG_W'(4))));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(tag_o) && $stable(match_o) && $stable(agg_o)));
endmodule

// File: tb/ctx_tag_unit_tb.sv
`timescale 1ns/1ps
module ctx_tag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [23:0] cid_i = '0;
  logic [3:0]  region_i = '0;
  logic [3:0]  type_i = '0;
  logic [7:0]  tag_i = '0;
  logic        out_valid_o;
  logic [7:0]  tag_o;
  logic        match_o;
  logic        agg_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       e_valid = 0;
  logic [7:0] e_tag = 0;
  logic       e_match = 0;
  logic       e_agg = 0;
  string      e_req = "R7";

  always #2.5 clk = ~clk;

  ctx_tag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .mode_i(mode_i),
    .cid_i(cid_i), .region_i(region_i), .type_i(type_i), .tag_i(tag_i),
    .out_valid_o(out_valid_o), .tag_o(tag_o), .match_o(match_o), .agg_o(agg_o)
  );

  // bit-serial reference: bits fed MSB first from a queue
  function automatic logic [7:0] ref_crc(input logic [23:0] c, input logic [3:0] r,
                                         input logic [3:0] t);
    bit q[$];
    int crc = 8'hFF;
    logic [31:0] w = {c, r, t};
    for (int i = 31; i >= 0; i--) q.push_back(w[i]);
    while (q.size() > 0) begin
      bit b = q.pop_front();
      bit fb = crc[7] ^ b;
      crc = (crc << 1) & 8'hFF;
      if (fb) crc = crc ^ 8'h07;
    end
    return crc[7:0];
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R6", "out_valid", 32'(out_valid_o), 32'(e_valid));
    chk(e_req, "tag", 32'(tag_o), 32'(e_tag));
    chk(e_req, "match", 32'(match_o), 32'(e_match));
    chk(e_req, "agg", 32'(agg_o), 32'(e_agg));
  endtask

  // compare last cycle's results, then present the next operation
  task automatic step(input bit v, input logic [1:0] m, input logic [23:0] c,
                      input logic [3:0] r, input logic [3:0] t, input logic [7:0] tg,
                      input string req);
    logic [7:0] crc;
    @(negedge clk);
    compare_all();
    in_valid_i = v; mode_i = m; cid_i = c; region_i = r; type_i = t; tag_i = tg;
    e_valid = v;
    if (v) begin
      crc = ref_crc(c, r, t);
      e_req = req;
      e_agg = (r == 4'd2) || (r == 4'd4);
      if (m[1]) begin
        e_tag = tg & 8'h7F; e_match = 0;
      end else begin
        e_tag = {1'b1, crc[6:0]};
        e_match = (m == 2'b01) && tg[7] && (tg[6:0] == crc[6:0]);
      end
    end else begin
      e_req = req;
    end
  endtask

  initial begin
    logic [7:0] good;
    @(negedge clk);
    // R7: outputs cleared during reset
    compare_all();
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 R2 R3: generate on corner IDs and random words
    step(1, 2'b00, 24'h000000, 4'h0, 4'h0, 8'h00, "R1 R2 R3");
    step(1, 2'b00, 24'hFFFFFF, 4'hF, 4'hF, 8'h00, "R1 R2 R3");
    step(1, 2'b00, 24'hFFFFFF, 4'h0, 4'h0, 8'h00, "R1 R2 R3");
    step(1, 2'b00, 24'h000000, 4'h3, 4'hC, 8'h00, "R1 R2 R3");
    for (int i = 0; i < 40; i++)
      step(1, 2'b00, 24'($urandom), 4'($urandom), 4'($urandom), 8'($urandom), "R1 R2 R3");

    // R4: check mode with good, stale and corrupted tags
    for (int i = 0; i < 20; i++) begin
      logic [23:0] c = 24'($urandom);
      logic [3:0]  r = 4'($urandom);
      logic [3:0]  t = 4'($urandom);
      good = {1'b1, ref_crc(c, r, t)[6:0]};
      step(1, 2'b01, c, r, t, good, "R4 match");
      step(1, 2'b01, c, r, t, good & 8'h7F, "R4 stale");
      step(1, 2'b01, c, r, t, good ^ 8'h01, "R4 corrupt");
    end
    good = {1'b1, ref_crc(24'hFFFFFF, 4'h4, 4'h1)[6:0]};
    step(1, 2'b01, 24'hFFFFFF, 4'h4, 4'h1, good, "R4 R8 corner");

    // R5: invalidate, both codes
    step(1, 2'b10, 24'h123456, 4'h1, 4'h2, 8'hFF, "R5");
    step(1, 2'b11, 24'h000000, 4'h2, 4'h0, 8'hA5, "R5 code3");
    step(1, 2'b10, 24'h0, 4'h0, 4'h0, 8'h3C, "R5 clear");

    // R8: region sweep
    for (int r = 0; r < 16; r++)
      step(1, 2'b00, 24'h00ABCD, 4'(r), 4'h5, 8'h00, "R8");

    // R9: idle cycles with noise on inputs hold the last results
    step(1, 2'b01, 24'h0, 4'h2, 4'h0, {1'b1, ref_crc(24'h0, 4'h2, 4'h0)[6:0]}, "R4 R8");
    for (int i = 0; i < 10; i++)
      step(0, 2'($urandom), 24'($urandom), 4'($urandom), 4'($urandom), 8'($urandom), "R9");
    // R6: back-to-back then single
    step(1, 2'b00, 24'h5A5A5A, 4'h4, 4'h7, 8'h00, "R6");
    step(0, 2'b00, 24'h0, 4'h0, 4'h0, 8'h00, "R6 R9");
    step(0, 2'b00, 24'h0, 4'h0, 4'h0, 8'h00, "R6 R9");

    // R7: reset mid-run clears outputs
    @(negedge clk);
    compare_all();
    rst_ni = 1'b0;
    #1;
    chk("R7", "valid in reset", 32'(out_valid_o), 32'd0);
    chk("R7", "tag in reset", 32'(tag_o), 32'd0);
    chk("R7", "match in reset", 32'(match_o), 32'd0);
    chk("R7", "agg in reset", 32'(agg_o), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule